// File: doc/BRIEF.md
# Rotation-Symmetric Configurable Logic Cell

This block is one tile of an asynchronous cellular array. Each of its four sides (north, east, south, west) carries one input and one output. Every side output is a four-input lookup function of the four side inputs. The lookup index is built relative to the direction the output faces, so a single 16-entry truth table gives the same behaviour whichever way the output points. Loading the same table into all four sides therefore yields a cell whose behaviour is unchanged when it is rotated by a quarter turn.

The 64 configuration bits are double-buffered. A serial shift chain, with a scan input and a scan output, is loaded one bit per clock while shifting is enabled. A bank of level-sensitive latches passes the chain contents through while the hold control is low and freezes them while hold is high. The side outputs are computed without any clock from the latched tables and the live side inputs, so the cell behaves as pure combinational logic once it is configured. A synchronous reset clears only the chain. A full clear is reset followed by a low pulse on hold.

Top module: `rotlut_cell`

## Requirements
- R1: The configuration holds four 16-entry tables, one for each side, with sides numbered north=0, east=1, south=2, west=3 (this is also their bit position in `side_in` and `side_out`). Entry e of the table for side s sits at chain bit 16*s+e.
- R2: `side_out[s]` equals entry idx of the latched table for side s, where idx bit 3 = `side_in[s]`, bit 2 = `side_in[(s+1)%4]`, bit 1 = `side_in[(s+2)%4]` and bit 0 = `side_in[(s+3)%4]`.
- R3: With one table loaded into all four sides, rotating the input vector one side clockwise (the input on side i moves to side (i+1)%4) rotates the output vector the same way.
- R4: On a rising clock edge with `shift_en` high and `rst` low, `scan_in` enters chain bit 0 and every other bit moves up one place. `scan_out` always shows chain bit 63 (entry 15 of the west table).
- R5: A rising clock edge with `rst` high clears every chain bit, and reset takes priority over shifting. While `hold` is high, the latched tables, and therefore the outputs, are left unchanged.
- R6: On a rising edge with `rst` and `shift_en` both low, the chain keeps its contents whatever `scan_in` does.
- R7: While `hold` is high, the latches keep their value, and chain activity has no effect on `side_out`.
- R8: While `hold` is low, the latches are transparent, so a change in the chain shows up on `side_out` without a further clock.
- R9: `side_out` responds to `side_in` changes with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock for the configuration chain |
| rst | input | 1 | Synchronous clear of the chain, active high |
| shift_en | input | 1 | Shift the chain by one bit on the next rising edge |
| scan_in | input | 1 | Serial configuration data into chain bit 0 |
| hold | input | 1 | High: latches keep their value; low: latches transparent |
| side_in | input | 4 | Side inputs, bit 0 north, 1 east, 2 south, 3 west |
| scan_out | output | 1 | Chain bit 63, for chaining into the next cell |
| side_out | output | 4 | Side outputs, same bit order as side_in |

## Verification
Two functions can act in the same cycle: a chain update (shift or reset) and the outputs through the latches. The bench provokes this by shifting in a full new configuration, and separately by pulsing reset, while hold is high. It judges the result with an exhaustive 16-pattern sweep of the side inputs, which must still match the old tables. It then opens the latches during a shift and expects the output to change at that very edge. The main sweeps cover several pseudo-random configurations, and a replicated table is used to check quarter-turn symmetry.

// File: rtl/rotlut_pkg.sv
package rotlut_pkg;

   // Largest side count the cell library supports (table size 2**MAX_SIDES).
   localparam int MAX_SIDES = 6;

   // Side reached by stepping 'step' positions clockwise from 'base'.
   function automatic int rot_side(input int base, input int step, input int n);
      return (base + step) % n;
   endfunction

endpackage

// File: rtl/rotlut_scan_chain.sv
module rotlut_scan_chain #(
   parameter int CFG_W = 64
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             shift_en,
   input  logic             scan_in,
   output logic [CFG_W-1:0] chain_q,
   output logic             scan_out
);

   generate
      if (CFG_W < 2) begin : g_bad_width
         $error("rotlut_scan_chain: CFG_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         chain_q <= '0;
      else if (shift_en)
         chain_q <= {chain_q[CFG_W-2:0], scan_in};
   end

   assign scan_out = chain_q[CFG_W-1];

   AST_CHAIN_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      shift_en |=> (rst || (chain_q[CFG_W-1:1] == $past(chain_q[CFG_W-2:0])
                            && chain_q[0] == $past(scan_in)))); // R4

   AST_CHAIN_STILL: assert property (@(posedge clk) disable iff (rst)
      !shift_en |=> (rst || $stable(chain_q))); // R6

   AST_CHAIN_CLEARED: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (chain_q == '0)); // R5

endmodule

// File: rtl/rotlut_latch_bank.sv
module rotlut_latch_bank #(
   parameter int CFG_W = 64
) (
   input  logic             hold,
   input  logic [CFG_W-1:0] d,
   output logic [CFG_W-1:0] q
);

   always_latch begin
      if (!hold)
         q = d;
   end

endmodule

// File: rtl/rotlut_side_eval.sv
module rotlut_side_eval #(
   parameter int N_SIDES = 4,
   parameter int SIDE    = 0,
   localparam int TBL_W  = 1 << N_SIDES
) (
   input  logic [TBL_W-1:0]   table_i,
   input  logic [N_SIDES-1:0] side_in,
   output logic               out_o
);

   generate
      if (SIDE < 0 || SIDE >= N_SIDES) begin : g_bad_side
         $error("rotlut_side_eval: SIDE out of range");
      end
   endgenerate

   logic [N_SIDES-1:0] idx;

   // Most significant index bit is the own-direction input, then clockwise.
   for (genvar k = 0; k < N_SIDES; k++) begin : g_idx
      assign idx[N_SIDES-1-k] = side_in[rotlut_pkg::rot_side(SIDE, k, N_SIDES)];
   end

   assign out_o = table_i[idx];

endmodule

// File: rtl/rotlut_cell.sv
module rotlut_cell #(
   parameter int N_SIDES = 4,
   localparam int TBL_W  = 1 << N_SIDES,
   localparam int CFG_W  = N_SIDES * TBL_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               shift_en,
   input  logic               scan_in,
   input  logic               hold,
   input  logic [N_SIDES-1:0] side_in,
   output logic               scan_out,
   output logic [N_SIDES-1:0] side_out
);

   generate
      if (N_SIDES < 2 || N_SIDES > rotlut_pkg::MAX_SIDES) begin : g_bad_sides
         $error("rotlut_cell: N_SIDES outside supported range");
      end
   endgenerate

   logic [CFG_W-1:0] chain_q;
   logic [CFG_W-1:0] lat_cfg;

   rotlut_scan_chain #(.CFG_W(CFG_W)) u_chain (
      .clk      (clk),
      .rst      (rst),
      .shift_en (shift_en),
      .scan_in  (scan_in),
      .chain_q  (chain_q),
      .scan_out (scan_out)
   );

   rotlut_latch_bank #(.CFG_W(CFG_W)) u_latch (
      .hold (hold),
      .d    (chain_q),
      .q    (lat_cfg)
   );

   for (genvar s = 0; s < N_SIDES; s++) begin : g_side
      rotlut_side_eval #(.N_SIDES(N_SIDES), .SIDE(s)) u_eval (
         .table_i (lat_cfg[s*TBL_W +: TBL_W]),
         .side_in (side_in),
         .out_o   (side_out[s])
      );
   end

   AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
      (hold && $past(hold)) |-> $stable(lat_cfg)); // R7

   AST_OPEN_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      !hold |-> (lat_cfg == chain_q)); // R8

endmodule

// File: tb/rotlut_cell_tb.sv
`timescale 1ns/1ps
module rotlut_cell_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       shift_en = 1'b0;
   logic       scan_in = 1'b0;
   logic       hold = 1'b0;
   logic [3:0] side_in = 4'h0;
   logic       scan_out;
   logic [3:0] side_out;

   int checks = 0;
   int fails  = 0;
   logic [63:0] cur_cfg;

   always #10 clk = ~clk;

   rotlut_cell #(.N_SIDES(4)) u_dut (
      .clk      (clk),
      .rst      (rst),
      .shift_en (shift_en),
      .scan_in  (scan_in),
      .hold     (hold),
      .side_in  (side_in),
      .scan_out (scan_out),
      .side_out (side_out)
   );

   function automatic logic model_out(input logic [63:0] cfg, input logic [3:0] v, input int s);
      logic [3:0] idx;
      idx = {v[s], v[(s+1)%4], v[(s+2)%4], v[(s+3)%4]};
      return cfg[s*16 + int'(idx)];
   endfunction

   function automatic logic [63:0] lfsr_next(input logic [63:0] x);
      return {x[62:0], x[63] ^ x[62] ^ x[60] ^ x[59]};
   endfunction

   function automatic logic [3:0] rotl(input logic [3:0] v);
      return {v[2:0], v[3]};
   endfunction

   task automatic check(input logic act, input logic exp, input string req, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   // Exhaustive sweep of side inputs, no clock involved (R9).
   task automatic sweep(input logic [63:0] cfg, input string req);
      for (int v = 0; v < 16; v++) begin
         side_in = 4'(v);
         #1;
         for (int s = 0; s < 4; s++)
            check(side_out[s], model_out(cfg, 4'(v), s), req, $sformatf("in=%h side=%0d", v, s));
      end
   endtask

   // Shift a full word in, MSB first, so that word bit i ends at chain bit i (R1, R4).
   task automatic load(input logic [63:0] w);
      for (int i = 63; i >= 0; i--) begin
         @(negedge clk);
         shift_en = 1'b1;
         scan_in  = w[i];
         @(posedge clk);
      end
      @(negedge clk);
      shift_en = 1'b0;
      scan_in  = 1'b0;
   endtask

   task automatic open_latch();
      @(negedge clk);
      hold = 1'b0;
      @(negedge clk);
      hold = 1'b1;
      #1;
   endtask

   initial begin
      #(20 * 100000);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [63:0] seed;
      logic [63:0] sym;
      logic [3:0]  o1;
      // Full reset: rst with latches open, then close.
      repeat (3) @(posedge clk);
      @(negedge clk);
      hold = 1'b1;
      rst  = 1'b0;
      #1;
      cur_cfg = '0;
      check(scan_out, 1'b0, "R5", "scan_out after reset");
      sweep(cur_cfg, "R5");

      // Several configurations: old tables survive loading (R7), new ones appear on open (R8, R2, R1).
      seed = 64'hACE1_2468_1357_9BDF;
      for (int t = 0; t < 6; t++) begin
         seed = lfsr_next(lfsr_next(lfsr_next(seed)));
         load(seed);
         check(scan_out, seed[63], "R4", "scan_out shows chain bit 63");
         sweep(cur_cfg, "R7");
         open_latch();
         cur_cfg = seed;
         sweep(cur_cfg, "R2");
      end

      // Scan-out walks down the word on further shifts (R4).
      load(64'hF0E1_D2C3_B4A5_9687);
      for (int k = 1; k <= 6; k++) begin
         @(negedge clk);
         shift_en = 1'b1;
         scan_in  = 1'b0;
         @(posedge clk);
         #2;
         check(scan_out, 1'(64'hF0E1_D2C3_B4A5_9687 >> (63 - k)), "R4", $sformatf("scan_out after %0d extra shifts", k));
      end
      @(negedge clk);
      shift_en = 1'b0;

      // Stalled chain ignores scan_in (R6).
      load(64'h1357_9BDF_0246_8ACE);
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         scan_in = k[0];
         @(posedge clk);
      end
      #2;
      check(scan_out, 1'b0, "R6", "scan_out unchanged while stalled");
      open_latch();
      cur_cfg = 64'h1357_9BDF_0246_8ACE;
      sweep(cur_cfg, "R6");

      // Reset with hold high leaves latched tables alone (R5), then full clear.
      @(negedge clk);
      rst = 1'b1;
      shift_en = 1'b1;
      scan_in = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      shift_en = 1'b0;
      scan_in = 1'b0;
      #1;
      check(scan_out, 1'b0, "R5", "scan_out after reset with shift request");
      sweep(cur_cfg, "R5");
      open_latch();
      cur_cfg = '0;
      sweep(cur_cfg, "R5");

      // Transparent latches: a single shift shows at the output at once (R8).
      side_in = 4'h0;
      @(negedge clk);
      hold = 1'b0;
      #1;
      check(side_out[0], 1'b0, "R8", "north before shift");
      shift_en = 1'b1;
      scan_in  = 1'b1;
      @(posedge clk);
      #2;
      check(side_out[0], 1'b1, "R8", "north right after shift edge");
      @(negedge clk);
      shift_en = 1'b0;
      scan_in  = 1'b0;
      hold = 1'b1;
      cur_cfg = 64'h1;

      // Quarter-turn symmetry with a replicated table (R3).
      sym = {4{16'hB38E}};
      load(sym);
      open_latch();
      cur_cfg = sym;
      sweep(cur_cfg, "R2");
      for (int v = 0; v < 16; v++) begin
         side_in = 4'(v);
         #1;
         o1 = side_out;
         side_in = rotl(4'(v));
         #1;
         for (int s = 0; s < 4; s++)
            check(side_out[s], rotl(o1)[s], "R3", $sformatf("rotated in=%h side=%0d", v, s));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule